// File: doc/BRIEF.md
# Segmented Address Translation Unit

This block turns a segment selector and an offset into a linear address. A 16-bit selector names a table (global or local) and an index within it. The unit checks the selector against the chosen table before any memory access is made. It then fetches the 8-byte descriptor over a simple read port. Finally it checks the descriptor's presence, privilege, write permission and offset limit, and adds the segment base to the offset.

Requests are taken one at a time over a valid/ready handshake. The result appears as a single-cycle response pulse that carries either a linear address or a fault code. Privilege levels run from 0 to 3, and a lower number means more privilege.

The table base and limit inputs, and the current privilege level, must stay stable while a request is in flight. Descriptor caching and gate handling are left to neighbouring logic.

Top module: `seg_xlate`

## Requirements
- R1: After reset, `req_ready` is 1 and both `rsp_valid` and `mem_rd_valid` are 0.
- R2: Selector bits 15:3 are the table index, bit 2 picks the local table when 1 and the global table when 0, and bits 1:0 are the requested level. The descriptor is read at the chosen table base + index*8.
- R3: A selector with index 0 and bit 2 clear is null. It faults with code 1 and makes no memory read. Index 0 in the local table is an ordinary entry.
- R4: When index*8+7 is greater than the chosen table's limit, the request faults with code 2 and makes no memory read.
- R5: The descriptor holds the base in bits 31:0, the limit in bits 59:32, the level in bits 61:60, a writable flag in bit 62 and a present flag in bit 63. A descriptor whose present flag is clear faults with code 3.
- R6: When the larger of the current level and the requested level exceeds the descriptor level, the request faults with code 4.
- R7: A write to a descriptor whose writable flag is clear faults with code 5. A read of the same descriptor is allowed.
- R8: An offset greater than the descriptor limit faults with code 6. An offset equal to the limit is allowed.
- R9: With no fault, the code is 0 and the linear address is base + offset modulo 2^32. On any fault, the linear address is 0.
- R10: When several faults apply, the lowest code is reported (1 through 6 in order).
- R11: `req_ready` is 0 from the accepting edge until the response has been given. Each accepted request yields exactly one `rsp_valid` pulse lasting one cycle.
- R12: While `mem_rd_valid` is 1 and `mem_rd_ready` is 0, the read request and its address stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Unit can accept a request |
| req_sel | input | 16 | Segment selector |
| req_ofs | input | 32 | Offset within the segment |
| req_write | input | 1 | 1 for write access, 0 for read |
| cur_pl | input | 2 | Current privilege level |
| gtab_base | input | 32 | Global table linear base |
| gtab_limit | input | 16 | Global table limit (last valid byte) |
| ltab_base | input | 32 | Local table linear base |
| ltab_limit | input | 16 | Local table limit (last valid byte) |
| mem_rd_valid | output | 1 | Descriptor read request |
| mem_rd_ready | input | 1 | Memory accepts the read |
| mem_rd_addr | output | 32 | Descriptor address |
| mem_rd_resp_valid | input | 1 | Read data returned |
| mem_rd_data | input | 64 | Descriptor contents |
| rsp_valid | output | 1 | Result pulse |
| rsp_linear | output | 32 | Linear address (0 on fault) |
| rsp_fault | output | 3 | Fault code, 0 when none |

## Verification
The bench targets the boundary entries of each table and offsets exactly at the limit or one past it. A design with an off-by-one in either compare would fault a legal access or let an illegal one through. It checks that index 0 in the local table is fetched normally, which catches a null test that ignores the table flag. It also checks that selector faults produce no memory read, which catches a design that fetches before checking.

The bench stacks several faults in one request to pin down the reporting order. It mixes current and requested levels so that a design using only one of them is caught. It also wraps the base-plus-offset sum past 2^32 and stalls the read port for several cycles.

// File: rtl/seg_xlate_pkg.sv
// Shared types and descriptor field positions for the segment translation unit.
// Assumes a 32-bit linear address and a 64-bit descriptor.
package seg_xlate_pkg;

    localparam int ADDR_W   = 32;
    localparam int SEL_W    = 16;
    localparam int IDX_W    = 13;
    localparam int DESC_W   = 64;
    localparam int DLIM_LO  = 32;
    localparam int DLIM_W   = 28;
    localparam int DPL_LO   = 60;
    localparam int WR_BIT   = 62;
    localparam int PRES_BIT = 63;

    typedef enum logic [2:0] {
        FLT_NONE   = 3'd0,
        FLT_NULL   = 3'd1,
        FLT_TBOUND = 3'd2,
        FLT_ABSENT = 3'd3,
        FLT_PRIV   = 3'd4,
        FLT_WPROT  = 3'd5,
        FLT_OFS    = 3'd6
    } fault_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SEL   = 3'd1,
        ST_FETCH = 3'd2,
        ST_WAIT  = 3'd3,
        ST_EVAL  = 3'd4,
        ST_DONE  = 3'd5
    } state_e;

endpackage

// File: rtl/seg_sel_check.sv
// Selector stage: picks the table, forms the descriptor address and
// flags null or out-of-table selectors. Purely combinational.
module seg_sel_check
    import seg_xlate_pkg::*;
#(
    parameter int TLIM_W = 16
) (
    input  logic [SEL_W-1:0]  sel,
    input  logic [ADDR_W-1:0] gbase,
    input  logic [TLIM_W-1:0] glim,
    input  logic [ADDR_W-1:0] lbase,
    input  logic [TLIM_W-1:0] llim,
    output logic [ADDR_W-1:0] rd_addr,
    output fault_e            fault
);
    localparam int SPAN_W = IDX_W + 3;
    localparam int CMP_W  = (TLIM_W > SPAN_W) ? TLIM_W : SPAN_W;

    logic [IDX_W-1:0]  idx;
    logic              use_local;
    logic [CMP_W-1:0]  span_end;
    logic [CMP_W-1:0]  lim_ext;

    // Field split and table choice.
    always_comb begin
        idx       = sel[SEL_W-1:3];
        use_local = sel[2];
        span_end  = CMP_W'({idx, 3'b111});
        lim_ext   = use_local ? CMP_W'(llim) : CMP_W'(glim);
        rd_addr   = (use_local ? lbase : gbase) + (ADDR_W'(idx) << 3);
    end

    // Selector fault priority: null before table bound.
    always_comb begin
        if (idx == '0 && !use_local)
            fault = FLT_NULL;
        else if (span_end > lim_ext)
            fault = FLT_TBOUND;
        else
            fault = FLT_NONE;
    end

endmodule

// File: rtl/seg_desc_check.sv
// Descriptor stage: decodes a fetched descriptor, applies presence,
// privilege, write and offset checks in priority order, and adds base
// to offset. Purely combinational.
module seg_desc_check
    import seg_xlate_pkg::*;
(
    input  logic [DESC_W-1:0] desc,
    input  logic [ADDR_W-1:0] ofs,
    input  logic              write,
    input  logic [1:0]        cpl,
    input  logic [1:0]        rpl,
    output logic [ADDR_W-1:0] linear,
    output fault_e            fault
);
    logic [ADDR_W-1:0] d_base;
    logic [DLIM_W-1:0] d_lim;
    logic [1:0]        d_pl;
    logic              d_wr;
    logic              d_pres;
    logic [1:0]        eff_pl;

    // Field decode and effective privilege.
    always_comb begin
        d_base = desc[ADDR_W-1:0];
        d_lim  = desc[DLIM_LO +: DLIM_W];
        d_pl   = desc[DPL_LO +: 2];
        d_wr   = desc[WR_BIT];
        d_pres = desc[PRES_BIT];
        eff_pl = (cpl > rpl) ? cpl : rpl;
        linear = d_base + ofs;
    end

    // Descriptor fault priority: presence, privilege, write, offset.
    always_comb begin
        if (!d_pres)
            fault = FLT_ABSENT;
        else if (eff_pl > d_pl)
            fault = FLT_PRIV;
        else if (write && !d_wr)
            fault = FLT_WPROT;
        else if (ofs > ADDR_W'(d_lim))
            fault = FLT_OFS;
        else
            fault = FLT_NONE;
    end

endmodule

// File: rtl/seg_ctrl.sv
// Sequencer: walks one request through selector check, descriptor read,
// descriptor check and the response cycle. Assumes response data is
// always accepted.
module seg_ctrl
    import seg_xlate_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   req_valid,
    input  logic   sel_ok,
    input  logic   rd_ready,
    input  logic   rd_resp_valid,
    output state_e state
);
    state_e nxt;

    // Next-state selection.
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (req_valid) nxt = ST_SEL;
            ST_SEL:   nxt = sel_ok ? ST_FETCH : ST_DONE;
            ST_FETCH: if (rd_ready) nxt = ST_WAIT;
            ST_WAIT:  if (rd_resp_valid) nxt = ST_EVAL;
            ST_EVAL:  nxt = ST_DONE;
            ST_DONE:  nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

endmodule

// File: rtl/seg_xlate.sv
// Segment translation top: captures a request, sequences the selector
// check, descriptor fetch and descriptor check, and registers the result.
// Assumes table registers and cur_pl are stable during a request.
module seg_xlate
    import seg_xlate_pkg::*;
#(
    parameter int TLIM_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [15:0]       req_sel,
    input  logic [31:0]       req_ofs,
    input  logic              req_write,
    input  logic [1:0]        cur_pl,
    input  logic [31:0]       gtab_base,
    input  logic [TLIM_W-1:0] gtab_limit,
    input  logic [31:0]       ltab_base,
    input  logic [TLIM_W-1:0] ltab_limit,
    output logic              mem_rd_valid,
    input  logic              mem_rd_ready,
    output logic [31:0]       mem_rd_addr,
    input  logic              mem_rd_resp_valid,
    input  logic [63:0]       mem_rd_data,
    output logic              rsp_valid,
    output logic [31:0]       rsp_linear,
    output logic [2:0]        rsp_fault
);
    state_e            state;
    logic [SEL_W-1:0]  sel_q;
    logic [ADDR_W-1:0] ofs_q;
    logic              wr_q;
    logic [1:0]        cpl_q;
    logic [DESC_W-1:0] desc_q;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] sel_addr;
    fault_e            sel_fault;
    logic [ADDR_W-1:0] d_linear;
    fault_e            d_fault;
    logic [ADDR_W-1:0] lin_q;
    fault_e            flt_q;

    seg_sel_check #(.TLIM_W(TLIM_W)) u_sel (
        .sel     (sel_q),
        .gbase   (gtab_base),
        .glim    (gtab_limit),
        .lbase   (ltab_base),
        .llim    (ltab_limit),
        .rd_addr (sel_addr),
        .fault   (sel_fault)
    );

    seg_desc_check u_desc (
        .desc   (desc_q),
        .ofs    (ofs_q),
        .write  (wr_q),
        .cpl    (cpl_q),
        .rpl    (sel_q[1:0]),
        .linear (d_linear),
        .fault  (d_fault)
    );

    seg_ctrl u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .sel_ok        (sel_fault == FLT_NONE),
        .rd_ready      (mem_rd_ready),
        .rd_resp_valid (mem_rd_resp_valid),
        .state         (state)
    );

    // Capture request fields on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
            ofs_q <= '0;
            wr_q  <= 1'b0;
            cpl_q <= '0;
        end else if (state == ST_IDLE && req_valid) begin
            sel_q <= req_sel;
            ofs_q <= req_ofs;
            wr_q  <= req_write;
            cpl_q <= cur_pl;
        end
    end

    // Hold the descriptor address and the returned descriptor.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            desc_q <= '0;
        end else begin
            if (state == ST_SEL)
                addr_q <= sel_addr;
            if (state == ST_WAIT && mem_rd_resp_valid)
                desc_q <= mem_rd_data;
        end
    end

    // Register the outcome from whichever stage decides it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lin_q <= '0;
            flt_q <= FLT_NONE;
        end else if (state == ST_SEL && sel_fault != FLT_NONE) begin
            lin_q <= '0;
            flt_q <= sel_fault;
        end else if (state == ST_EVAL) begin
            lin_q <= (d_fault == FLT_NONE) ? d_linear : '0;
            flt_q <= d_fault;
        end
    end

    // Port drive from state and held results.
    always_comb begin
        req_ready    = (state == ST_IDLE);
        mem_rd_valid = (state == ST_FETCH);
        mem_rd_addr  = addr_q;
        rsp_valid    = (state == ST_DONE);
        rsp_linear   = lin_q;
        rsp_fault    = flt_q;
    end

endmodule

// File: rtl/seg_xlate_chk.sv
// Protocol checker for seg_xlate; observes ports only. Bound below.
module seg_xlate_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic        mem_rd_valid,
    input logic        mem_rd_ready,
    input logic [31:0] mem_rd_addr,
    input logic        rsp_valid,
    input logic [31:0] rsp_linear,
    input logic [2:0]  rsp_fault
);
    a_r11_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    a_r11_no_read_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid |-> !req_ready);

    a_r12_hold_read: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));

    a_r9_zero_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault != 3'd0) |-> (rsp_linear == 32'd0));

    a_r10_code_range: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_fault <= 3'd6));

endmodule

bind seg_xlate seg_xlate_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .mem_rd_valid (mem_rd_valid),
    .mem_rd_ready (mem_rd_ready),
    .mem_rd_addr  (mem_rd_addr),
    .rsp_valid    (rsp_valid),
    .rsp_linear   (rsp_linear),
    .rsp_fault    (rsp_fault)
);

// File: tb/seg_xlate_tb.sv
`timescale 1ns/1ps
module seg_xlate_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [15:0] req_sel = '0;
    logic [31:0] req_ofs = '0;
    logic        req_write = 1'b0;
    logic [1:0]  cur_pl = '0;
    logic [31:0] gtab_base = 32'h0010_0000;
    logic [15:0] gtab_limit = 16'h00FF;
    logic [31:0] ltab_base = 32'h0020_0000;
    logic [15:0] ltab_limit = 16'h003F;
    logic        mem_rd_valid;
    logic        mem_rd_ready = 1'b0;
    logic [31:0] mem_rd_addr;
    logic        mem_rd_resp_valid = 1'b0;
    logic [63:0] mem_rd_data = '0;
    logic        rsp_valid;
    logic [31:0] rsp_linear;
    logic [2:0]  rsp_fault;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    seg_xlate u_dut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] mkdesc(input logic [31:0] base, input logic [27:0] lim,
                                           input logic [1:0] pl, input logic wr, input logic pres);
        return {pres, wr, pl, lim, base};
    endfunction

    // Runs one request, serving the descriptor read with a given stall.
    task automatic xlate(input logic [15:0] sel, input logic [31:0] ofs, input logic wr,
                         input logic [1:0] cpl, input logic [63:0] desc, input int delay,
                         output logic [2:0] f, output logic [31:0] lin, output int nrd,
                         output logic [31:0] raddr, output int busy_rdy, output int pulse_bad);
        bit done = 0;
        nrd = 0; busy_rdy = 0; pulse_bad = 0; raddr = '0; f = 3'd7; lin = '1;
        @(negedge clk);
        req_sel = sel; req_ofs = ofs; req_write = wr; cur_pl = cpl; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        for (int c = 0; c < 40 && !done; c++) begin
            if (rsp_valid) begin
                f = rsp_fault; lin = rsp_linear; done = 1;
            end else begin
                if (req_ready) busy_rdy++;
                if (mem_rd_valid) begin
                    raddr = mem_rd_addr; nrd++;
                    repeat (delay) begin
                        @(negedge clk);
                        if (!mem_rd_valid || mem_rd_addr !== raddr) pulse_bad++;
                    end
                    mem_rd_ready = 1'b1; @(negedge clk); mem_rd_ready = 1'b0;
                    mem_rd_resp_valid = 1'b1; mem_rd_data = desc;
                    @(negedge clk); mem_rd_resp_valid = 1'b0;
                end else begin
                    @(negedge clk);
                end
            end
        end
        if (!done) begin
            errors++; checks++;
            $display("FAIL R11 no response actual=none expected=pulse");
        end
        @(negedge clk);
        if (rsp_valid) pulse_bad++;
    endtask

    logic [2:0]  f;
    logic [31:0] lin, ra;
    int nrd, br, pb;
    logic [63:0] good = 64'h0;

    task automatic t_reset();
        chk("R1 req_ready", 32'(req_ready), 1);
        chk("R1 rsp_valid", 32'(rsp_valid), 0);
        chk("R1 mem_rd_valid", 32'(mem_rd_valid), 0);
    endtask

    task automatic t_global_ok();
        xlate(16'h0028, 32'h1234, 1'b1, 2'd0, mkdesc(32'h4000_0000, 28'hFFFF, 2'd0, 1, 1), 0,
              f, lin, nrd, ra, br, pb);
        chk("R2 global addr", ra, 32'h0010_0028);
        chk("R9 fault", 32'(f), 0);
        chk("R9 linear", lin, 32'h4000_1234);
        chk("R11 busy ready", 32'(br), 0);
        chk("R11 single pulse", 32'(pb), 0);
    endtask

    task automatic t_local_ok();
        xlate(16'h001D, 32'h100, 1'b0, 2'd1, mkdesc(32'h8000_0000, 28'h100, 2'd2, 0, 1), 0,
              f, lin, nrd, ra, br, pb);
        chk("R2 local addr", ra, 32'h0020_0018);
        chk("R8 ofs at limit ok", 32'(f), 0);
        chk("R9 local linear", lin, 32'h8000_0100);
        xlate(16'h001D, 32'h101, 1'b0, 2'd1, mkdesc(32'h8000_0000, 28'h100, 2'd2, 0, 1), 0,
              f, lin, nrd, ra, br, pb);
        chk("R8 ofs past limit", 32'(f), 6);
        chk("R9 zero linear on fault", lin, 0);
    endtask

    task automatic t_null();
        xlate(16'h0003, 32'h0, 1'b0, 2'd0, good, 0, f, lin, nrd, ra, br, pb);
        chk("R3 null code", 32'(f), 1);
        chk("R3 null no read", 32'(nrd), 0);
        xlate(16'h0004, 32'h10, 1'b0, 2'd0, mkdesc(32'h100, 28'hFF, 2'd0, 0, 1), 0,
              f, lin, nrd, ra, br, pb);
        chk("R3 local idx0 addr", ra, 32'h0020_0000);
        chk("R3 local idx0 ok", 32'(f), 0);
    endtask

    task automatic t_bound();
        xlate(16'h0100, 32'h0, 1'b0, 2'd0, good, 0, f, lin, nrd, ra, br, pb);
        chk("R4 global idx32 code", 32'(f), 2);
        chk("R4 global idx32 no read", 32'(nrd), 0);
        xlate(16'h00F8, 32'h0, 1'b0, 2'd0, mkdesc(32'h0, 28'h1, 2'd0, 0, 1), 0,
              f, lin, nrd, ra, br, pb);
        chk("R4 global idx31 ok", 32'(f), 0);
        chk("R4 global idx31 addr", ra, 32'h0010_00F8);
        xlate(16'h0044, 32'h0, 1'b0, 2'd0, good, 0, f, lin, nrd, ra, br, pb);
        chk("R4 local idx8 code", 32'(f), 2);
        chk("R4 local idx8 no read", 32'(nrd), 0);
    endtask

    task automatic t_absent();
        xlate(16'h0008, 32'h0, 1'b0, 2'd0, mkdesc(32'h5000, 28'hFF, 2'd3, 1, 0), 0,
              f, lin, nrd, ra, br, pb);
        chk("R5 absent code", 32'(f), 3);
    endtask

    task automatic t_priv();
        xlate(16'h0008, 32'h0, 1'b0, 2'd3, mkdesc(32'h5000, 28'hFF, 2'd2, 1, 1), 0,
              f, lin, nrd, ra, br, pb);
        chk("R6 cpl above dpl", 32'(f), 4);
        xlate(16'h000B, 32'h0, 1'b0, 2'd0, mkdesc(32'h5000, 28'hFF, 2'd2, 1, 1), 0,
              f, lin, nrd, ra, br, pb);
        chk("R6 rpl above dpl", 32'(f), 4);
        xlate(16'h0009, 32'h4, 1'b0, 2'd2, mkdesc(32'h5000, 28'hFF, 2'd2, 1, 1), 0,
              f, lin, nrd, ra, br, pb);
        chk("R6 equal level ok", 32'(f), 0);
        chk("R6 linear", lin, 32'h5004);
    endtask

    task automatic t_wprot();
        xlate(16'h0008, 32'h0, 1'b1, 2'd0, mkdesc(32'h6000, 28'hFF, 2'd0, 0, 1), 0,
              f, lin, nrd, ra, br, pb);
        chk("R7 write readonly", 32'(f), 5);
        xlate(16'h0008, 32'h8, 1'b0, 2'd0, mkdesc(32'h6000, 28'hFF, 2'd0, 0, 1), 0,
              f, lin, nrd, ra, br, pb);
        chk("R7 read readonly ok", 32'(f), 0);
    endtask

    task automatic t_wrap();
        xlate(16'h0010, 32'h2000, 1'b0, 2'd0, mkdesc(32'hFFFF_F000, 28'hFFFFF, 2'd0, 1, 1), 0,
              f, lin, nrd, ra, br, pb);
        chk("R9 wrap fault", 32'(f), 0);
        chk("R9 wrap linear", lin, 32'h0000_1000);
    endtask

    task automatic t_prio();
        xlate(16'h0008, 32'h500, 1'b1, 2'd3, mkdesc(32'h0, 28'h10, 2'd0, 0, 0), 0,
              f, lin, nrd, ra, br, pb);
        chk("R10 absent first", 32'(f), 3);
        xlate(16'h0008, 32'h500, 1'b1, 2'd3, mkdesc(32'h0, 28'h10, 2'd0, 0, 1), 0,
              f, lin, nrd, ra, br, pb);
        chk("R10 priv before write", 32'(f), 4);
        xlate(16'h0008, 32'h500, 1'b1, 2'd0, mkdesc(32'h0, 28'h10, 2'd0, 0, 1), 0,
              f, lin, nrd, ra, br, pb);
        chk("R10 write before ofs", 32'(f), 5);
        gtab_limit = 16'h0003;
        xlate(16'h0000, 32'h0, 1'b0, 2'd0, good, 0, f, lin, nrd, ra, br, pb);
        chk("R10 null before bound", 32'(f), 1);
        gtab_limit = 16'h00FF;
    endtask

    task automatic t_stall();
        xlate(16'h0018, 32'h20, 1'b0, 2'd0, mkdesc(32'h7000, 28'hFF, 2'd0, 1, 1), 4,
              f, lin, nrd, ra, br, pb);
        chk("R12 held during stall", 32'(pb), 0);
        chk("R12 one read", 32'(nrd), 1);
        chk("R12 result", lin, 32'h7020);
        chk("R11 busy ready stall", 32'(br), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_global_ok();
        t_local_ok();
        t_null();
        t_bound();
        t_absent();
        t_priv();
        t_wprot();
        t_wrap();
        t_prio();
        t_stall();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule